// File: doc/BRIEF.md
# I3C Target Common-Command Responder

This block handles the common-command traffic of an I3C target that runs in single data rate only. A byte-level framer sits in front of it and passes on bus events as single-cycle pulses: a START or repeated START, a STOP, an address with its direction bit, each received data byte, and each request for a byte to transmit. The responder recognises the broadcast address and decodes the command code that follows. For every address phase it decides whether to acknowledge. It keeps the dynamic address and the event-enable flags, and it supplies the bytes of the direct get commands.

A direct command remains selected across repeated STARTs, so the controller can address several targets in turn. The command ends at STOP. Dynamic-address arbitration and in-band-interrupt arbitration on the wires are handled elsewhere. The block only exposes whether a dynamic address is held, the enable flags, and a request to join address assignment. The provisional ID is built from parameters for the maker, device and instance fields, and from the pin-derived static address for its low 12 bits.

Top module: `i3c_ccc_responder`

## Requirements
- R1: After reset no dynamic address is held, the interrupt enable is 1, the controller-role and hot-join enables are 0, the join request is 0, and no acknowledge or transmit pulse is issued.
- R2: The cycle after an address phase that follows a START, `ack_valid` pulses. `ack` is 1 when the address is 7'h7E with write direction (`addr_rnw`=0). A read to 7'h7E, or any other address outside a direct command, is not acknowledged.
- R3: The enable-events command (code 0x00 broadcast, 0x80 direct) sets, and the disable-events command (0x81 direct) clears, the interrupt enable from event-byte bit 0, the controller-role enable from bit 1 and the hot-join enable from bit 3. All other event-byte bits have no effect.
- R4: Code 0x87 acknowledges a write to the static address only while no dynamic address is held. Its data byte loads bits [7:1] as the dynamic address when bit 0 is 0; a byte with bit 0 set is ignored.
- R5: When the static address is 7'h5E, code 0x87 is never acknowledged.
- R6: Code 0x88 acknowledges a write only to the held dynamic address and replaces it with data bits [7:1] when bit 0 is 0.
- R7: Code 0x06 drops the dynamic address. Code 0x07 raises `daa_join` only when no dynamic address is held. `daa_join` falls at STOP.
- R8: Code 0x8D returns 6 bytes, most significant first: maker code in [47:33], 0 in [32], device ID in [31:16], instance in [15:12], and {4'b0000, static address, 1'b0} in [11:0].
- R9: Code 0x8E returns 0x03, code 0x8F returns 0x63 and code 0x90 returns 0x00, 0x00. `tx_last` marks the final byte. A request past the end returns 0x00 with `tx_last` set. Each `tx_valid` pulse comes one cycle after a `tx_req`.
- R10: A direct command is acknowledged only if the address matches and the direction is right: read for the get codes (0x8D, 0x8E, 0x8F, 0x90), write for the others. A read request without acknowledged selection yields no `tx_valid`.
- R11: An unsupported code changes no state, and the bytes after it are ignored.
- R12: A direct command stays in force across repeated STARTs, and each new address is matched again. After STOP, an address other than 7'h7E write is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| static_addr | input | 7 | Pin-derived static address |
| bus_start | input | 1 | START or repeated START seen |
| bus_stop | input | 1 | STOP seen |
| addr_valid | input | 1 | Address phase received |
| addr_in | input | 7 | Received address |
| addr_rnw | input | 1 | Direction bit, 1 = read |
| rx_valid | input | 1 | Data byte received |
| rx_byte | input | 8 | Received data byte |
| tx_req | input | 1 | Framer requests a byte to send |
| ack_valid | output | 1 | Acknowledge decision is valid |
| ack | output | 1 | 1 = acknowledge address |
| tx_valid | output | 1 | Transmit byte is valid |
| tx_byte | output | 8 | Byte to transmit |
| tx_last | output | 1 | Byte is the last of the response |
| da_valid | output | 1 | Dynamic address held |
| dyn_addr | output | 7 | Dynamic address |
| int_en | output | 1 | Interrupt requests enabled |
| cr_en | output | 1 | Controller-role requests enabled |
| hj_en | output | 1 | Hot-join enabled |
| daa_join | output | 1 | Request to join dynamic address assignment |

## Verification
The hardest state to reach is a direct command that stays open over several repeated STARTs. Within it, one selection changes the match condition for the next one. Examples are a set-from-static whose first data byte is rejected for bit 0 and whose retry succeeds, or a rename followed by a read to the new address. The stimulus chains these inside a single command before any STOP, then repeats them with the restricted static address and the wrong directions. A behavioural model with a byte queue predicts every acknowledge, byte and flag on each clock.

// File: rtl/i3c_ccc_pkg.sv
package i3c_ccc_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = 3;
    localparam int PID_W  = 48;

    localparam int EVB_INT = 0;
    localparam int EVB_CR  = 1;
    localparam int EVB_HJ  = 3;

    localparam logic [ADDR_W-1:0] BCAST_ADDR      = 7'h7E;
    localparam logic [ADDR_W-1:0] RESTRICTED_ADDR = 7'h5E;

    localparam logic [BYTE_W-1:0] BCR_BYTE    = 8'h03;
    localparam logic [BYTE_W-1:0] DCR_BYTE    = 8'h63;
    localparam logic [BYTE_W-1:0] STATUS_BYTE = 8'h00;

    typedef enum logic [3:0] {
        CK_NONE, CK_ENEC_B, CK_RSTDAA, CK_ENTDAA,
        CK_ENEC_D, CK_DISEC_D, CK_SETDASA, CK_SETNEWDA,
        CK_GETPID, CK_GETBCR, CK_GETDCR, CK_GETSTATUS, CK_RSTACT
    } ccc_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_ADDR, PH_CODE, PH_BDATA,
        PH_DIR, PH_DADDR, PH_SELW, PH_SELR
    } phase_e;

    typedef enum logic [1:0] {EV_NOP, EV_SET, EV_CLR} ev_op_e;

    typedef struct packed {
        logic hj;
        logic cr;
        logic intr;
    } ev_mask_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } dyn_addr_t;

    function automatic ccc_e decode_ccc(input logic [BYTE_W-1:0] code);
        case (code)
            8'h00:   return CK_ENEC_B;
            8'h06:   return CK_RSTDAA;
            8'h07:   return CK_ENTDAA;
            8'h80:   return CK_ENEC_D;
            8'h81:   return CK_DISEC_D;
            8'h87:   return CK_SETDASA;
            8'h88:   return CK_SETNEWDA;
            8'h8D:   return CK_GETPID;
            8'h8E:   return CK_GETBCR;
            8'h8F:   return CK_GETDCR;
            8'h90:   return CK_GETSTATUS;
            8'h9A:   return CK_RSTACT;
            default: return CK_NONE;
        endcase
    endfunction

    function automatic logic is_get(input ccc_e k);
        return (k == CK_GETPID) || (k == CK_GETBCR) ||
               (k == CK_GETDCR) || (k == CK_GETSTATUS);
    endfunction

    function automatic logic is_direct(input ccc_e k);
        return is_get(k) || (k == CK_ENEC_D) || (k == CK_DISEC_D) ||
               (k == CK_SETDASA) || (k == CK_SETNEWDA) || (k == CK_RSTACT);
    endfunction

    function automatic logic [IDX_W-1:0] get_len(input ccc_e k);
        case (k)
            CK_GETPID:    return IDX_W'(PID_W / BYTE_W);
            CK_GETBCR:    return IDX_W'(1);
            CK_GETDCR:    return IDX_W'(1);
            CK_GETSTATUS: return IDX_W'(2);
            default:      return '0;
        endcase
    endfunction

endpackage

// File: rtl/i3c_ccc_flags.sv
module i3c_ccc_flags
    import i3c_ccc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ev_op_e            ev_op,
    input  ev_mask_t          ev_mask,
    input  logic              da_load,
    input  logic [ADDR_W-1:0] da_new,
    input  logic              da_clear,
    output dyn_addr_t         da,
    output logic              int_en,
    output logic              cr_en,
    output logic              hj_en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            da     <= '0;
            int_en <= 1'b1;
            cr_en  <= 1'b0;
            hj_en  <= 1'b0;
        end else begin
            if (da_clear)
                da.valid <= 1'b0;
            else if (da_load)
                da <= '{valid: 1'b1, addr: da_new};
            case (ev_op)
                EV_SET: begin
                    if (ev_mask.intr) int_en <= 1'b1;
                    if (ev_mask.cr)   cr_en  <= 1'b1;
                    if (ev_mask.hj)   hj_en  <= 1'b1;
                end
                EV_CLR: begin
                    if (ev_mask.intr) int_en <= 1'b0;
                    if (ev_mask.cr)   cr_en  <= 1'b0;
                    if (ev_mask.hj)   hj_en  <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    AST_DA_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        (da_load && !da_clear) |=> (da.valid && da.addr == $past(da_new))); // R4
    AST_DA_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
        da_clear |=> !da.valid); // R7
    AST_EV_NOP_STABLE: assert property (@(posedge clk) disable iff (rst)
        (ev_op == EV_NOP) |=> ($stable(int_en) && $stable(cr_en) && $stable(hj_en))); // R3

endmodule

// File: rtl/i3c_ccc_getmux.sv
module i3c_ccc_getmux
    import i3c_ccc_pkg::*;
#(
    parameter logic [14:0] PID_MFG  = 15'h011B,
    parameter logic [15:0] PID_DEV  = 16'h00A5,
    parameter logic [3:0]  PID_INST = 4'h0
) (
    input  ccc_e              kind,
    input  logic [IDX_W-1:0]  idx,
    input  logic [ADDR_W-1:0] static_addr,
    output logic [BYTE_W-1:0] byte_out,
    output logic              last
);

    logic [PID_W-1:0]  pid;
    logic [PID_W-1:0]  pid_sh;
    logic [IDX_W-1:0]  len;
    logic              in_range;

    assign pid      = {PID_MFG, 1'b0, PID_DEV, PID_INST, 4'b0000, static_addr, 1'b0};
    assign pid_sh   = pid << {idx, 3'b000};
    assign len      = get_len(kind);
    assign in_range = (idx < len);
    assign last     = ({1'b0, idx} + (IDX_W+1)'(1)) >= {1'b0, len};

    always_comb begin
        byte_out = '0;
        if (in_range) begin
            case (kind)
                CK_GETPID:    byte_out = pid_sh[PID_W-1 -: BYTE_W];
                CK_GETBCR:    byte_out = BCR_BYTE;
                CK_GETDCR:    byte_out = DCR_BYTE;
                CK_GETSTATUS: byte_out = STATUS_BYTE;
                default:      byte_out = '0;
            endcase
        end
    end

endmodule

// File: rtl/i3c_ccc_responder.sv
module i3c_ccc_responder
    import i3c_ccc_pkg::*;
#(
    parameter logic [14:0] PID_MFG  = 15'h011B,
    parameter logic [15:0] PID_DEV  = 16'h00A5,
    parameter logic [3:0]  PID_INST = 4'h0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [6:0]  static_addr,
    input  logic        bus_start,
    input  logic        bus_stop,
    input  logic        addr_valid,
    input  logic [6:0]  addr_in,
    input  logic        addr_rnw,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        tx_req,
    output logic        ack_valid,
    output logic        ack,
    output logic        tx_valid,
    output logic [7:0]  tx_byte,
    output logic        tx_last,
    output logic        da_valid,
    output logic [6:0]  dyn_addr,
    output logic        int_en,
    output logic        cr_en,
    output logic        hj_en,
    output logic        daa_join
);

    phase_e           phase;
    ccc_e             ccc;
    logic [IDX_W-1:0] idx;
    dyn_addr_t        da;

    logic e_stop, e_start, e_addr, e_rx, e_tx;
    assign e_stop  = bus_stop;
    assign e_start = !bus_stop && bus_start;
    assign e_addr  = !bus_stop && !bus_start && addr_valid;
    assign e_rx    = !bus_stop && !bus_start && !addr_valid && rx_valid;
    assign e_tx    = !bus_stop && !bus_start && !addr_valid && !rx_valid && tx_req;

    ccc_e code_kind;
    logic is_bcast_w;
    logic hit;
    assign code_kind  = decode_ccc(rx_byte);
    assign is_bcast_w = (addr_in == BCAST_ADDR) && !addr_rnw;

    always_comb begin
        hit = 1'b0;
        if (ccc == CK_SETDASA)
            hit = !addr_rnw && !da.valid && (addr_in == static_addr) &&
                  (static_addr != RESTRICTED_ADDR);
        else if (is_get(ccc))
            hit = addr_rnw && da.valid && (addr_in == da.addr);
        else if (is_direct(ccc))
            hit = !addr_rnw && da.valid && (addr_in == da.addr);
    end

    ev_op_e           ev_op;
    ev_mask_t         ev_mask;
    logic             da_load;
    logic             da_clear;

    assign ev_mask = '{hj: rx_byte[EVB_HJ], cr: rx_byte[EVB_CR], intr: rx_byte[EVB_INT]};

    always_comb begin
        ev_op    = EV_NOP;
        da_load  = 1'b0;
        da_clear = 1'b0;
        if (e_rx) begin
            case (phase)
                PH_CODE:  da_clear = (code_kind == CK_RSTDAA);
                PH_BDATA: ev_op = EV_SET;
                PH_SELW: begin
                    case (ccc)
                        CK_ENEC_D:   ev_op   = EV_SET;
                        CK_DISEC_D:  ev_op   = EV_CLR;
                        CK_SETDASA,
                        CK_SETNEWDA: da_load = !rx_byte[0];
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    i3c_ccc_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .ev_op    (ev_op),
        .ev_mask  (ev_mask),
        .da_load  (da_load),
        .da_new   (rx_byte[BYTE_W-1:1]),
        .da_clear (da_clear),
        .da       (da),
        .int_en   (int_en),
        .cr_en    (cr_en),
        .hj_en    (hj_en)
    );

    logic [BYTE_W-1:0] mux_byte;
    logic              mux_last;

    i3c_ccc_getmux #(
        .PID_MFG  (PID_MFG),
        .PID_DEV  (PID_DEV),
        .PID_INST (PID_INST)
    ) u_getmux (
        .kind        (ccc),
        .idx         (idx),
        .static_addr (static_addr),
        .byte_out    (mux_byte),
        .last        (mux_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            ccc       <= CK_NONE;
            idx       <= '0;
            ack_valid <= 1'b0;
            ack       <= 1'b0;
            tx_valid  <= 1'b0;
            tx_byte   <= '0;
            tx_last   <= 1'b0;
            daa_join  <= 1'b0;
        end else begin
            ack_valid <= 1'b0;
            ack       <= 1'b0;
            tx_valid  <= 1'b0;
            tx_byte   <= '0;
            tx_last   <= 1'b0;
            if (e_stop) begin
                phase    <= PH_IDLE;
                ccc      <= CK_NONE;
                daa_join <= 1'b0;
            end else if (e_start) begin
                if (phase inside {PH_DIR, PH_DADDR, PH_SELW, PH_SELR})
                    phase <= PH_DADDR;
                else
                    phase <= PH_ADDR;
            end else if (e_addr) begin
                if (phase == PH_ADDR) begin
                    ack_valid <= 1'b1;
                    ack       <= is_bcast_w;
                    phase     <= is_bcast_w ? PH_CODE : PH_IDLE;
                end else if (phase == PH_DADDR) begin
                    ack_valid <= 1'b1;
                    if (is_bcast_w) begin
                        ack   <= 1'b1;
                        phase <= PH_CODE;
                        ccc   <= CK_NONE;
                    end else if (hit) begin
                        ack   <= 1'b1;
                        phase <= is_get(ccc) ? PH_SELR : PH_SELW;
                        idx   <= '0;
                    end else begin
                        phase <= PH_DIR;
                    end
                end
            end else if (e_rx) begin
                case (phase)
                    PH_CODE: begin
                        ccc <= code_kind;
                        if (code_kind == CK_ENEC_B)
                            phase <= PH_BDATA;
                        else if (is_direct(code_kind))
                            phase <= PH_DIR;
                        else
                            phase <= PH_IDLE;
                        if (code_kind == CK_ENTDAA && !da.valid)
                            daa_join <= 1'b1;
                    end
                    PH_BDATA: phase <= PH_IDLE;
                    PH_SELW:  phase <= PH_DIR;
                    default: ;
                endcase
            end else if (e_tx && phase == PH_SELR) begin
                tx_valid <= 1'b1;
                tx_byte  <= mux_byte;
                tx_last  <= mux_last;
                if (idx != '1)
                    idx <= idx + 1'b1;
            end
        end
    end

    assign da_valid = da.valid;
    assign dyn_addr = da.addr;

    AST_ACK_AFTER_ADDR: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> $past(addr_valid)); // R2
    AST_TX_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> $past(tx_req)); // R9
    AST_NO_RESTRICTED_DASA: assert property (@(posedge clk) disable iff (rst)
        (e_addr && phase == PH_DADDR && ccc == CK_SETDASA && !is_bcast_w &&
         static_addr == RESTRICTED_ADDR) |=> !ack); // R5
    AST_JOIN_NEEDS_NO_DA: assert property (@(posedge clk) disable iff (rst)
        $rose(daa_join) |-> !da_valid); // R7
    AST_STOP_DROPS_JOIN: assert property (@(posedge clk) disable iff (rst)
        bus_stop |=> !daa_join); // R7
    AST_TX_ONLY_SELECTED: assert property (@(posedge clk) disable iff (rst)
        (tx_req && phase != PH_SELR) |=> !tx_valid); // R10

endmodule

// File: tb/i3c_ccc_responder_tb.sv
module i3c_ccc_responder_tb;

    localparam logic [14:0] T_MFG  = 15'h011B;
    localparam logic [15:0] T_DEV  = 16'h3C5A;
    localparam logic [3:0]  T_INST = 4'h9;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst;
    logic [6:0] static_addr;
    logic       bus_start, bus_stop, addr_valid, addr_rnw, rx_valid, tx_req;
    logic [6:0] addr_in;
    logic [7:0] rx_byte;
    logic       ack_valid, ack, tx_valid, tx_last, da_valid, int_en, cr_en, hj_en, daa_join;
    logic [7:0] tx_byte;
    logic [6:0] dyn_addr;

    i3c_ccc_responder #(.PID_MFG(T_MFG), .PID_DEV(T_DEV), .PID_INST(T_INST)) u_dut (
        .clk(clk), .rst(rst), .static_addr(static_addr),
        .bus_start(bus_start), .bus_stop(bus_stop),
        .addr_valid(addr_valid), .addr_in(addr_in), .addr_rnw(addr_rnw),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req),
        .ack_valid(ack_valid), .ack(ack), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .tx_last(tx_last), .da_valid(da_valid), .dyn_addr(dyn_addr),
        .int_en(int_en), .cr_en(cr_en), .hj_en(hj_en), .daa_join(daa_join)
    );

    int    checks = 0;
    int    errors = 0;
    string req = "R1";
    bit    done = 0;

    // behavioural reference state
    int         m_ph;   // 0 idle,1 addr,2 code,3 bcast data,4 direct,5 direct addr,6 set sel,7 get sel
    int         m_ccc;
    bit         m_dav, m_int, m_cr, m_hj, m_join;
    logic [6:0] m_da;
    logic [7:0] q[$];
    bit         e_ackv, e_ack, e_txv, e_txl;
    logic [7:0] e_txd;

    function automatic bit c_direct(int c);
        return c inside {'h80, 'h81, 'h87, 'h88, 'h8D, 'h8E, 'h8F, 'h90, 'h9A};
    endfunction
    function automatic bit c_get(int c);
        return c inside {'h8D, 'h8E, 'h8F, 'h90};
    endfunction

    task automatic model();
        logic [47:0] p;
        bit hitm;
        e_ackv = 0; e_ack = 0; e_txv = 0; e_txl = 0; e_txd = 0;
        if (rst) begin
            m_ph = 0; m_ccc = -1; m_dav = 0; m_da = 0;
            m_int = 1; m_cr = 0; m_hj = 0; m_join = 0; q.delete();
            return;
        end
        if (bus_stop) begin
            m_ph = 0; m_ccc = -1; m_join = 0;
        end else if (bus_start) begin
            m_ph = (m_ph >= 4) ? 5 : 1;
        end else if (addr_valid) begin
            if (m_ph == 1) begin
                e_ackv = 1;
                if (addr_in == 7'h7E && !addr_rnw) begin e_ack = 1; m_ph = 2; end
                else m_ph = 0;
            end else if (m_ph == 5) begin
                e_ackv = 1;
                if (m_ccc == 'h87)
                    hitm = !addr_rnw && !m_dav && addr_in == static_addr && static_addr != 7'h5E;
                else if (c_get(m_ccc))
                    hitm = addr_rnw && m_dav && addr_in == m_da;
                else
                    hitm = c_direct(m_ccc) && !addr_rnw && m_dav && addr_in == m_da;
                if (addr_in == 7'h7E && !addr_rnw) begin
                    e_ack = 1; m_ph = 2; m_ccc = -1;
                end else if (hitm) begin
                    e_ack = 1;
                    if (c_get(m_ccc)) begin
                        m_ph = 7;
                        q.delete();
                        case (m_ccc)
                            'h8D: begin
                                p = {T_MFG, 1'b0, T_DEV, T_INST, 4'b0000, static_addr, 1'b0};
                                for (int k = 0; k < 6; k++) q.push_back(p[47 - 8*k -: 8]);
                            end
                            'h8E: q.push_back(8'h03);
                            'h8F: q.push_back(8'h63);
                            default: begin q.push_back(8'h00); q.push_back(8'h00); end
                        endcase
                    end else m_ph = 6;
                end else m_ph = 4;
            end
        end else if (rx_valid) begin
            if (m_ph == 2) begin
                m_ccc = rx_byte;
                if (rx_byte == 8'h00) m_ph = 3;
                else if (rx_byte == 8'h06) begin m_dav = 0; m_ph = 0; end
                else if (rx_byte == 8'h07) begin if (!m_dav) m_join = 1; m_ph = 0; end
                else if (c_direct(rx_byte)) m_ph = 4;
                else begin m_ph = 0; m_ccc = -1; end
            end else if (m_ph == 3) begin
                if (rx_byte[0]) m_int = 1;
                if (rx_byte[1]) m_cr = 1;
                if (rx_byte[3]) m_hj = 1;
                m_ph = 0;
            end else if (m_ph == 6) begin
                if (m_ccc == 'h80) begin
                    if (rx_byte[0]) m_int = 1;
                    if (rx_byte[1]) m_cr = 1;
                    if (rx_byte[3]) m_hj = 1;
                end else if (m_ccc == 'h81) begin
                    if (rx_byte[0]) m_int = 0;
                    if (rx_byte[1]) m_cr = 0;
                    if (rx_byte[3]) m_hj = 0;
                end else if ((m_ccc == 'h87 || m_ccc == 'h88) && !rx_byte[0]) begin
                    m_dav = 1; m_da = rx_byte[7:1];
                end
                m_ph = 4;
            end
        end else if (tx_req && m_ph == 7) begin
            e_txv = 1;
            if (q.size() > 0) begin
                e_txd = q.pop_front();
                e_txl = (q.size() == 0);
            end else begin
                e_txd = 8'h00; e_txl = 1;
            end
        end
    endtask

    task automatic step();
        bit ok;
        @(posedge clk);
        #2;
        model();
        ok = (ack_valid == e_ackv) && (!e_ackv || ack == e_ack) &&
             (tx_valid == e_txv) && (!e_txv || (tx_byte == e_txd && tx_last == e_txl)) &&
             (da_valid == m_dav) && (!m_dav || dyn_addr == m_da) &&
             (int_en == m_int) && (cr_en == m_cr) && (hj_en == m_hj) && (daa_join == m_join);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s t=%0t: actual ackv=%0b ack=%0b txv=%0b tx=%h last=%0b dav=%0b da=%h int=%0b cr=%0b hj=%0b join=%0b expected ackv=%0b ack=%0b txv=%0b tx=%h last=%0b dav=%0b da=%h int=%0b cr=%0b hj=%0b join=%0b",
                     req, $time, ack_valid, ack, tx_valid, tx_byte, tx_last, da_valid, dyn_addr,
                     int_en, cr_en, hj_en, daa_join, e_ackv, e_ack, e_txv, e_txd, e_txl,
                     m_dav, m_da, m_int, m_cr, m_hj, m_join);
        end
        @(negedge clk);
        bus_start = 0; bus_stop = 0; addr_valid = 0; rx_valid = 0; tx_req = 0;
    endtask

    task automatic t_start();                 bus_start = 1; step(); endtask
    task automatic t_stop();                  bus_stop = 1;  step(); endtask
    task automatic t_addr(logic [6:0] a, logic r); addr_in = a; addr_rnw = r; addr_valid = 1; step(); endtask
    task automatic t_rx(logic [7:0] b);       rx_byte = b; rx_valid = 1; step(); endtask
    task automatic t_tx();                    tx_req = 1; step(); endtask
    task automatic ccc_open(logic [7:0] code); t_start(); t_addr(7'h7E, 0); t_rx(code); endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; static_addr = 7'h48;
        bus_start = 0; bus_stop = 0; addr_valid = 0; rx_valid = 0; tx_req = 0;
        addr_in = 0; addr_rnw = 0; rx_byte = 0;
        @(negedge clk);
        req = "R1"; step(); step(); step();
        rst = 0; step(); step();

        req = "R2";  // broadcast address acknowledge rules
        t_start(); t_addr(7'h7E, 1); t_stop();
        t_start(); t_addr(7'h7E, 0); t_stop();
        t_start(); t_addr(7'h48, 0); t_stop();

        req = "R11"; // unsupported code and trailing bytes
        ccc_open(8'h55); t_rx(8'h0B); t_rx(8'h44); t_stop();
        ccc_open(8'h8C); t_start(); t_addr(7'h48, 0); t_rx(8'h44); t_stop();

        req = "R4";  // set from static, bad bit 0 then good, same command
        ccc_open(8'h87);
        t_start(); t_addr(7'h48, 0); t_rx(8'h45);
        req = "R12";
        t_start(); t_addr(7'h48, 0); t_rx(8'h44);
        t_start(); t_addr(7'h48, 0); t_stop();
        req = "R12"; t_start(); t_addr(7'h22, 0); t_stop();

        req = "R7";  // drop address, join request only without address
        ccc_open(8'h07); t_stop();
        ccc_open(8'h06); t_stop();
        ccc_open(8'h07); step(); t_stop(); step();

        req = "R5";  // restricted static address
        static_addr = 7'h5E;
        ccc_open(8'h87); t_start(); t_addr(7'h5E, 0); t_rx(8'h44); t_stop();
        static_addr = 7'h48;
        req = "R4";
        ccc_open(8'h87); t_start(); t_addr(7'h48, 0); t_rx(8'h44); t_stop();

        req = "R6";  // rename
        ccc_open(8'h88); t_start(); t_addr(7'h48, 0);
        t_start(); t_addr(7'h22, 0); t_rx(8'h60); t_stop();
        req = "R13";
        ccc_open(8'h88); t_start(); t_addr(7'h30, 1); t_rx(8'h70); t_stop();

        req = "R3";  // event enables
        ccc_open(8'h81); t_start(); t_addr(7'h30, 0); t_rx(8'h01); t_stop();
        ccc_open(8'h00); t_rx(8'h0B); t_stop();
        ccc_open(8'h81); t_start(); t_addr(7'h30, 0); t_rx(8'h0A); t_stop();
        ccc_open(8'h00); t_rx(8'hF4); t_stop();
        ccc_open(8'h80); t_start(); t_addr(7'h30, 0); t_rx(8'h08); t_stop();
        ccc_open(8'h81); t_start(); t_addr(7'h30, 0); t_rx(8'hF7); t_stop();

        req = "R8";  // provisional ID
        ccc_open(8'h8D); t_start(); t_addr(7'h30, 1);
        for (int i = 0; i < 7; i++) t_tx();
        t_stop();
        static_addr = 7'h4B;
        ccc_open(8'h8D); t_start(); t_addr(7'h30, 1);
        for (int i = 0; i < 6; i++) t_tx();
        t_stop();
        static_addr = 7'h48;

        req = "R9";  // fixed bytes
        ccc_open(8'h8E); t_start(); t_addr(7'h30, 1); t_tx(); t_tx(); t_stop();
        ccc_open(8'h8F); t_start(); t_addr(7'h30, 1); t_tx(); t_tx();
        t_start(); t_addr(7'h30, 1); t_tx(); t_stop();
        ccc_open(8'h90); t_start(); t_addr(7'h30, 1); t_tx(); t_tx(); t_tx(); t_stop();
        ccc_open(8'h9A); t_start(); t_addr(7'h30, 0); t_rx(8'h01); t_stop();

        req = "R10"; // wrong address / direction
        ccc_open(8'h8E); t_start(); t_addr(7'h31, 1); t_tx(); t_stop();
        ccc_open(8'h8F); t_start(); t_addr(7'h30, 0); t_tx(); t_stop();
        t_tx();

        req = "R12"; // after STOP only broadcast write is acknowledged
        t_start(); t_addr(7'h30, 1); t_tx(); t_stop();
        ccc_open(8'h8E); t_start(); t_addr(7'h31, 1);
        t_start(); t_addr(7'h30, 1); t_tx(); t_stop();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule